// File: doc/BRIEF.md
# Strobed Handshake Data Port

This block is one data port with a three-line peripheral handshake and an interrupt request. It works in one of two directions, chosen by a static select input. As an input port, a peripheral pulls its strobe low to capture the pin data into a holding register. The block then raises a buffer-full flag, and an interrupt request when enabled, until the host reads the port. As an output port, a host write captures bus data into a holding register that drives the pins. An active-low output-full line then tells the peripheral that data is waiting, until the peripheral answers with an acknowledge pulse.

The peripheral's strobe and its acknowledge share one active-low handshake input. That input crosses into the clock domain through a synchronizer before any edge is detected. Host read and write are active-high, synchronous level pulses. Their leading and trailing edges have distinct meanings: a leading edge drops the interrupt, and a trailing edge ends a read or commits a write. The interrupt enable comes from outside, and when it is clear the request is masked at once. Address decode and configuration storage sit in the host-side logic around this block.

Top module: `hsp_port`

## Requirements
- R1: After reset, buffer-full is low, output-full (active low) is high, the interrupt request is low and the output holding register is all zeros.
- R2: In input direction (dir_in_i = 1), the pin data is captured while the synchronized strobe is low. After the strobe returns high, host_data_o keeps returning the captured value even when the pins change.
- R3: In input direction, buffer-full rises no later than the third clock edge after the strobe input goes low. It stays high through a host read and falls on the clock edge where rd_i is seen low after being high.
- R4: In input direction with the enable set, the interrupt request rises no later than the third clock edge after the strobe returns high. It falls on the first clock edge at which rd_i is high.
- R5: In output direction (dir_in_i = 0), the first clock edge at which wr_i is high copies host_data_i to port_data_o, which then holds. port_oe_o is high in output direction and low in input direction.
- R6: In output direction, output-full goes low on the clock edge where wr_i is seen low after being high. It returns high no later than the third clock edge after the acknowledge input goes low.
- R7: In output direction with the enable set, the interrupt request rises no later than the third clock edge after the acknowledge returns high. It falls on the first clock edge at which wr_i is high.
- R8: When the enable is low, the interrupt output is low in the same cycle, and buffer-full and output-full keep their values. A request dropped this way does not come back when the enable is set again.
- R9: A strobe or acknowledge that completes while the enable is low raises no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_in_i | input | 1 | 1 = strobed input, 0 = strobed output |
| inte_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Host read of this port, active high level |
| wr_i | input | 1 | Host write of this port, active high level |
| host_data_i | input | W | Host write data |
| host_data_o | output | W | Host read data: input register or output register by direction |
| port_data_i | input | W | Peripheral pin input data |
| port_data_o | output | W | Output holding register to the pins |
| port_oe_o | output | 1 | Pin output enable |
| hs_ni | input | 1 | Peripheral strobe (input) or acknowledge (output), active low, asynchronous |
| ibf_o | output | 1 | Input buffer full |
| obf_no | output | 1 | Output buffer full, active low |
| intr_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the interrupt is never raised without the enable. They also check that buffer-full only falls at the end of a host read, that output-full only falls at the end of a host write, and that the pin data changes only after a write begins in output direction. The bench scenarios show the rest: the latency through the synchronizer, that the captured value holds while the pins move, that interrupts are not raised for handshakes finished while masked, and that a masked request stays dropped.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} hsp_dir_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } hsp_evt_t;
endpackage

// File: rtl/hsp_edge.sv
module hsp_edge
  import hsp_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     d_i,
  output hsp_evt_t evt_o
);
  logic lvl, prev_q;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= {STAGES{RST_VAL}};
        end else begin
          chain_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign lvl = chain_q[STAGES-1];
    end else begin : g_direct
      assign lvl = d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl;
  end

  assign evt_o.lvl  = lvl;
  assign evt_o.rise = lvl & ~prev_q;
  assign evt_o.fall = ~lvl & prev_q;
endmodule

// File: rtl/hsp_in_path.sv
module hsp_in_path
  import hsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inte_i,
  input  hsp_evt_t     stb_i,
  input  hsp_evt_t     rd_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] data_o,
  output logic         ibf_o,
  output logic         intr_o
);
  logic [W-1:0] data_q;
  logic         ibf_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (!inte_i) intr_q <= 1'b0;
      if (en_i) begin
        if (!stb_i.lvl) data_q <= pins_i;
        if (!stb_i.lvl)     ibf_q <= 1'b1;
        else if (rd_i.fall) ibf_q <= 1'b0;
        if (inte_i) begin
          if (stb_i.rise)     intr_q <= 1'b1;
          else if (rd_i.rise) intr_q <= 1'b0;
        end
      end
    end
  end

  assign data_o = data_q;
  assign ibf_o  = ibf_q;
  assign intr_o = intr_q;
endmodule

// File: rtl/hsp_out_path.sv
module hsp_out_path
  import hsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inte_i,
  input  hsp_evt_t     ack_i,
  input  hsp_evt_t     wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         intr_o
);
  logic [W-1:0] data_q;
  logic         full_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (!inte_i) intr_q <= 1'b0;
      if (en_i) begin
        if (wr_i.rise) data_q <= wdata_i;
        if (wr_i.fall)      full_q <= 1'b1;
        else if (!ack_i.lvl) full_q <= 1'b0;
        if (inte_i) begin
          if (ack_i.rise)     intr_q <= 1'b1;
          else if (wr_i.rise) intr_q <= 1'b0;
        end
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign intr_o = intr_q;
endmodule

// File: rtl/hsp_port.sv
module hsp_port
  import hsp_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_in_i,
  input  logic         inte_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] host_data_i,
  output logic [W-1:0] host_data_o,
  input  logic [W-1:0] port_data_i,
  output logic [W-1:0] port_data_o,
  output logic         port_oe_o,
  input  logic         hs_ni,
  output logic         ibf_o,
  output logic         obf_no,
  output logic         intr_o
);
  hsp_dir_e     dir;
  hsp_evt_t     hs_evt, rd_evt, wr_evt;
  logic [W-1:0] in_data, out_data;
  logic         in_full, in_intr, out_full, out_intr;

  assign dir = hsp_dir_e'(dir_in_i);

  hsp_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
    .clk_i, .rst_ni, .d_i(hs_ni), .evt_o(hs_evt));
  hsp_edge #(.STAGES(0), .RST_VAL(1'b0)) u_rd_edge (
    .clk_i, .rst_ni, .d_i(rd_i), .evt_o(rd_evt));
  hsp_edge #(.STAGES(0), .RST_VAL(1'b0)) u_wr_edge (
    .clk_i, .rst_ni, .d_i(wr_i), .evt_o(wr_evt));

  hsp_in_path #(.W(W)) u_in (
    .clk_i, .rst_ni, .en_i(dir == DIR_IN), .inte_i,
    .stb_i(hs_evt), .rd_i(rd_evt), .pins_i(port_data_i),
    .data_o(in_data), .ibf_o(in_full), .intr_o(in_intr));

  hsp_out_path #(.W(W)) u_out (
    .clk_i, .rst_ni, .en_i(dir == DIR_OUT), .inte_i,
    .ack_i(hs_evt), .wr_i(wr_evt), .wdata_i(host_data_i),
    .data_o(out_data), .full_o(out_full), .intr_o(out_intr));

  always_comb begin
    if (dir == DIR_IN) begin
      host_data_o = in_data;
      ibf_o       = in_full;
      obf_no      = 1'b1;
      intr_o      = inte_i & in_intr;
      port_oe_o   = 1'b0;
    end else begin
      host_data_o = out_data;
      ibf_o       = 1'b0;
      obf_no      = ~out_full;
      intr_o      = inte_i & out_intr;
      port_oe_o   = 1'b1;
    end
  end

  assign port_data_o = out_data;
endmodule

// File: rtl/hsp_port_chk.sv
module hsp_port_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         dir_in_i,
  input logic         inte_i,
  input logic         rd_i,
  input logic         wr_i,
  input logic [W-1:0] port_data_o,
  input logic         ibf_o,
  input logic         obf_no,
  input logic         intr_o
);
  AST_INTR_NEEDS_INTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> inte_i); // R8

  AST_IBF_CLEAR_ON_READ_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ibf_o) && dir_in_i && $past(dir_in_i)) |-> ($past(rd_i, 2) && !$past(rd_i))); // R3

  AST_OBF_SET_ON_WRITE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(obf_no) && !dir_in_i && !$past(dir_in_i)) |-> ($past(wr_i, 2) && !$past(wr_i))); // R6

  AST_PORT_DATA_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_data_o) |-> ($past(wr_i) && !$past(dir_in_i))); // R5
endmodule

bind hsp_port hsp_port_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .dir_in_i, .inte_i, .rd_i, .wr_i,
  .port_data_o, .ibf_o, .obf_no, .intr_o);

// File: tb/hsp_port_bench.sv
module hsp_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dir_in_i = 1'b1, inte_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, hs_ni = 1'b1;
  logic [W-1:0] host_data_i = '0, port_data_i = '0;
  logic [W-1:0] host_data_o, port_data_o;
  logic         port_oe_o, ibf_o, obf_no, intr_o;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  hsp_port #(.W(W)) u_hsp_port (
    .clk_i(clk), .rst_ni, .dir_in_i, .inte_i, .rd_i, .wr_i,
    .host_data_i, .host_data_o, .port_data_i, .port_data_o, .port_oe_o,
    .hs_ni, .ibf_o, .obf_no, .intr_o);

  // {direction_in, enable, data}
  typedef struct packed { logic dir_in; logic en; logic [W-1:0] data; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 8'hA5}, '{1'b1, 1'b0, 8'h3C}, '{1'b0, 1'b1, 8'h5A},
    '{1'b0, 1'b0, 8'hC3}, '{1'b1, 1'b1, 8'h00}, '{1'b0, 1'b1, 8'hFF}};

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic in_xfer(logic [W-1:0] v, logic en);
    dir_in_i = 1'b1; inte_i = en; port_data_i = v; hs_ni = 1'b0;
    tick(3);
    chk("R3 ibf after strobe", ibf_o, 1);
    hs_ni = 1'b1;
    tick(3);
    chk(en ? "R4 intr after strobe" : "R9 no intr when masked", intr_o, en);
    port_data_i = ~v;
    tick(1);
    chk("R2 captured data holds", host_data_o, v);
    chk("R5 oe low in input", port_oe_o, 0);
    rd_i = 1'b1;
    tick(1);
    chk("R4 intr cleared at read start", intr_o, 0);
    chk("R3 ibf held during read", ibf_o, 1);
    rd_i = 1'b0;
    tick(1);
    chk("R3 ibf cleared at read end", ibf_o, 0);
  endtask

  task automatic out_xfer(logic [W-1:0] v, logic en);
    dir_in_i = 1'b0; inte_i = en; host_data_i = v; wr_i = 1'b1;
    tick(1);
    chk("R5 port data at write start", port_data_o, v);
    chk("R7 intr cleared at write start", intr_o, 0);
    chk("R5 oe high in output", port_oe_o, 1);
    host_data_i = ~v; wr_i = 1'b0;
    tick(1);
    chk("R6 obf low after write", obf_no, 0);
    chk("R5 port data holds", port_data_o, v);
    hs_ni = 1'b0;
    tick(3);
    chk("R6 obf high after ack", obf_no, 1);
    hs_ni = 1'b1;
    tick(3);
    chk(en ? "R7 intr after ack" : "R9 no intr when masked", intr_o, en);
  endtask

  initial begin
    tick(2);
    chk("R1 ibf reset", ibf_o, 0);
    chk("R1 obf reset", obf_no, 1);
    chk("R1 intr reset", intr_o, 0);
    chk("R1 port data reset", port_data_o, 0);
    rst_ni = 1'b1;
    tick(2);

    foreach (VECS[i]) begin
      if (VECS[i].dir_in) in_xfer(VECS[i].data, VECS[i].en);
      else                out_xfer(VECS[i].data, VECS[i].en);
    end

    // R8: masking drops intr at once, flags untouched, no return
    dir_in_i = 1'b1; inte_i = 1'b1; port_data_i = 8'h66; hs_ni = 1'b0;
    tick(3);
    hs_ni = 1'b1;
    tick(3);
    chk("R8 intr before mask", intr_o, 1);
    #1 inte_i = 1'b0;
    #0.5;
    chk("R8 intr low same cycle", intr_o, 0);
    tick(2);
    chk("R8 ibf unchanged by mask", ibf_o, 1);
    inte_i = 1'b1;
    tick(2);
    chk("R8 intr stays dropped", intr_o, 0);
    rd_i = 1'b1; tick(1); rd_i = 1'b0; tick(1);
    chk("R3 ibf cleared", ibf_o, 0);

    // R8: output-full unchanged by mask
    dir_in_i = 1'b0; host_data_i = 8'h12; wr_i = 1'b1; tick(1); wr_i = 1'b0; tick(1);
    inte_i = 1'b0;
    tick(2);
    chk("R8 obf unchanged by mask", obf_no, 0);
    hs_ni = 1'b0; tick(3); hs_ni = 1'b1; tick(3);
    chk("R9 no intr after masked ack", intr_o, 0);

    // R5: read in input direction must not move port data
    dir_in_i = 1'b1; rd_i = 1'b1; tick(1); rd_i = 1'b0; tick(1);
    chk("R5 port data unaffected in input", port_data_o, 8'h12);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule